// File: doc/BRIEF.md
# Indirect Accelerator Descriptor Read Port

This block sits on the device side of a host register bus. It gives the host read access to a fixed descriptor for each of up to 64 accelerator slots, one 32-bit dword at a time. The host first selects a slot through an index register. It then writes a byte offset into an offset register. That write starts a fetch from an internal descriptor store, which answers after a fixed number of cycles.

While a fetch is in flight, bit 31 of the offset register reads as zero. When the fetched dword has been placed in the data register, bit 31 reads as one. The host polls that bit and then reads the data register.

The descriptor store is computed from parameters and from the slot index. A presence mask marks which slots hold an accelerator, so the slot map can have gaps. An empty slot answers every offset with zero.

Top module: `afu_desc_port`

## Requirements
- R1: The register map uses word addresses. Address 0 is the slot index, held in bits 5:0; the other bits read as zero and writes to them are dropped. Address 1 is the offset register: bit 31 is the ready flag and bits 30:0 are the byte offset. Address 2 is the data register. Address 3 reads as zero. After reset, all three registers read as zero.
- R2: A write to address 1 with bit 31 clear stores the offset and clears the ready flag. The ready flag and the fetched dword both appear exactly LATENCY clock edges after the write edge.
- R3: A write to address 1 with bit 31 set is dropped. The stored offset, the ready flag and the data register all keep their values.
- R4: An offset write that arrives while a fetch is still pending abandons the old fetch. The result then reflects the new offset and arrives LATENCY edges after the second write.
- R5: Any write to the index register clears the ready flag and cancels a pending fetch. The flag stays low until the next accepted offset write completes.
- R6: The data register keeps its last fetched value while the ready flag is low. It changes only when a fetch completes.
- R7: For a present slot, offset 0x00 returns {16'h0058, HDR_MAJOR, HDR_MINOR}. For a slot whose bit in PRESENT_MASK is clear, every offset returns zero.
- R8: The 24-byte name starts at offset 0x04, with the first character in bits 7:0. Offset 0x04 returns 32'h2D636361, which reads "acc-". Offset 0x08 returns {16'h0, 8'h30+idx[2:0], 8'h30+idx[5:3]}. Offsets 0x0C through 0x18 return zero.
- R9: Offset 0x1C returns {AFU_MAJOR, AFU_MINOR, 2'b01, 2'b10, 4'h0, 2'b00, idx}. Here bits 15:14 and 13:12 are the two type fields and bits 7:0 are the profile.
- R10: The MMIO words are as follows.
  - 0x20 returns {10'h0, idx, 13'h0, 3'd2}, which is global BAR 2.
  - 0x24 returns 32'h1.
  - 0x28 returns GLOBAL_SIZE.
  - 0x30 returns {10'h0, idx, 13'h0, 3'd4}, which is per-process BAR 4.
  - 0x34 returns zero.
  - 0x38 returns PP_STRIDE.
  - 0x3C returns {24'h0, MEM_LOG2}.
- R11: Offsets at or above 0x58 return zero, and so do unlisted offsets below 0x58. Offset bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register word address |
| regWe | input | 1 | Write strobe |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |

## Verification
Headers are fetched from present slots and from empty slots. This separates the presence-mask lookup from the field packing.

Name, type and MMIO words are read for slot indices 2 and 4. Because these indices differ, any field that ignores the index or sits at the wrong bit position shows up as a mismatch.

Offsets beyond the template, gaps inside it, and an unaligned offset check the bounds and alignment decode.

Three interleavings test the handshake:
- a write with the flag bit set, in the middle of a session;
- an offset rewrite while a fetch is pending;
- an index write while a fetch is pending.

Together they tell a fetch that is abandoned, cancelled or ignored apart from one that completes with stale data.

// File: rtl/afu_desc_pkg.sv
package afu_desc_pkg;
  localparam int DATA_W   = 32;
  localparam int IDX_W    = 6;
  localparam int OFF_W    = 31;
  localparam int ADDR_IDX = 0;
  localparam int ADDR_OFF = 1;
  localparam int ADDR_DAT = 2;
  localparam logic [15:0] TEMPLATE_LEN = 16'h0058;

  typedef struct packed {
    logic idxWr;
    logic offWr;
    logic fetchDone;
  } strobes_t;
endpackage

// File: rtl/afu_desc_rom.sv
module afu_desc_rom
  import afu_desc_pkg::*;
#(
  parameter logic [63:0] PRESENT_MASK = 64'h0000_0000_0000_0015,
  parameter logic [7:0]  HDR_MAJOR    = 8'h01,
  parameter logic [7:0]  HDR_MINOR    = 8'h00,
  parameter logic [7:0]  AFU_MAJOR    = 8'h02,
  parameter logic [7:0]  AFU_MINOR    = 8'h03,
  parameter logic [31:0] GLOBAL_SIZE  = 32'h0200_0000,
  parameter logic [31:0] PP_STRIDE    = 32'h0001_0000,
  parameter logic [7:0]  MEM_LOG2     = 8'd24
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [OFF_W-1:0]  byteOff,
  output logic [DATA_W-1:0] word
);
  localparam int WORD_SEL_W = 5;

  logic present;
  logic inRange;
  logic [WORD_SEL_W-1:0] wordSel;
  logic [7:0] digitHi;
  logic [7:0] digitLo;

  assign present = PRESENT_MASK[idx];
  assign inRange = (byteOff < OFF_W'(TEMPLATE_LEN));
  assign wordSel = byteOff[WORD_SEL_W+1:2];
  assign digitHi = 8'h30 + {5'b0, idx[5:3]};
  assign digitLo = 8'h30 + {5'b0, idx[2:0]};

  always_comb begin
    word = '0;
    if (present && inRange) begin
      case (wordSel)
        5'h00: word = {TEMPLATE_LEN, HDR_MAJOR, HDR_MINOR};
        5'h01: word = 32'h2D63_6361;
        5'h02: word = {16'h0000, digitLo, digitHi};
        5'h07: word = {AFU_MAJOR, AFU_MINOR, 2'b01, 2'b10, 4'h0, 2'b00, idx};
        5'h08: word = {10'h000, idx, 13'h0000, 3'd2};
        5'h09: word = 32'h0000_0001;
        5'h0A: word = GLOBAL_SIZE;
        5'h0C: word = {10'h000, idx, 13'h0000, 3'd4};
        5'h0D: word = 32'h0000_0000;
        5'h0E: word = PP_STRIDE;
        5'h0F: word = {24'h000000, MEM_LOG2};
        default: word = '0;
      endcase
    end
  end
endmodule

// File: rtl/afu_desc_ctrl.sv
module afu_desc_ctrl
  import afu_desc_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic              flagBit,
  output strobes_t          strb
);
  localparam int CNT_W = (LATENCY < 2) ? 1 : $clog2(LATENCY);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

  logic pending;
  logic [CNT_W-1:0] cnt;

  assign strb.idxWr     = regWe && (regAddr == ADDR_W'(ADDR_IDX));
  assign strb.offWr     = regWe && (regAddr == ADDR_W'(ADDR_OFF)) && !flagBit;
  assign strb.fetchDone = pending && (cnt == '0) && !strb.offWr && !strb.idxWr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (strb.offWr) begin
      pending <= 1'b1;
      cnt     <= CNT_LOAD;
    end else if (strb.idxWr || strb.fetchDone) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (pending) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/afu_desc_dp.sv
module afu_desc_dp
  import afu_desc_pkg::*;
#(
  parameter int          ADDR_W       = 2,
  parameter logic [63:0] PRESENT_MASK = 64'h0000_0000_0000_0015,
  parameter logic [7:0]  HDR_MAJOR    = 8'h01,
  parameter logic [7:0]  HDR_MINOR    = 8'h00,
  parameter logic [7:0]  AFU_MAJOR    = 8'h02,
  parameter logic [7:0]  AFU_MINOR    = 8'h03,
  parameter logic [31:0] GLOBAL_SIZE  = 32'h0200_0000,
  parameter logic [31:0] PP_STRIDE    = 32'h0001_0000,
  parameter logic [7:0]  MEM_LOG2     = 8'd24
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  output logic [IDX_W-1:0]  idxQ,
  output logic [OFF_W-1:0]  offsetQ,
  output logic [DATA_W-1:0] dataQ,
  output logic              validQ
);
  logic [DATA_W-1:0] romWord;

  afu_desc_rom #(
    .PRESENT_MASK(PRESENT_MASK), .HDR_MAJOR(HDR_MAJOR), .HDR_MINOR(HDR_MINOR),
    .AFU_MAJOR(AFU_MAJOR), .AFU_MINOR(AFU_MINOR), .GLOBAL_SIZE(GLOBAL_SIZE),
    .PP_STRIDE(PP_STRIDE), .MEM_LOG2(MEM_LOG2)
  ) u_rom (
    .idx(idxQ),
    .byteOff(offsetQ),
    .word(romWord)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ    <= '0;
      offsetQ <= '0;
      dataQ   <= '0;
      validQ  <= 1'b0;
    end else begin
      if (strb.idxWr) begin
        idxQ   <= regWdata[IDX_W-1:0];
        validQ <= 1'b0;
      end
      if (strb.offWr) begin
        offsetQ <= regWdata[OFF_W-1:0];
        validQ  <= 1'b0;
      end
      if (strb.fetchDone) begin
        dataQ  <= romWord;
        validQ <= 1'b1;
      end
    end
  end

  always_comb begin
    case (regAddr)
      ADDR_W'(ADDR_IDX): regRdata = {{(DATA_W-IDX_W){1'b0}}, idxQ};
      ADDR_W'(ADDR_OFF): regRdata = {validQ, offsetQ};
      ADDR_W'(ADDR_DAT): regRdata = dataQ;
      default:           regRdata = '0;
    endcase
  end
endmodule

// File: rtl/afu_desc_port.sv
module afu_desc_port
  import afu_desc_pkg::*;
#(
  parameter int          ADDR_W       = 2,
  parameter int          LATENCY      = 4,
  parameter logic [63:0] PRESENT_MASK = 64'h0000_0000_0000_0015,
  parameter logic [7:0]  HDR_MAJOR    = 8'h01,
  parameter logic [7:0]  HDR_MINOR    = 8'h00,
  parameter logic [7:0]  AFU_MAJOR    = 8'h02,
  parameter logic [7:0]  AFU_MINOR    = 8'h03,
  parameter logic [31:0] GLOBAL_SIZE  = 32'h0200_0000,
  parameter logic [31:0] PP_STRIDE    = 32'h0001_0000,
  parameter logic [7:0]  MEM_LOG2     = 8'd24
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata
);
  strobes_t          strb;
  logic [IDX_W-1:0]  idxQ;
  logic [OFF_W-1:0]  offsetQ;
  logic [DATA_W-1:0] dataQ;
  logic              validQ;

  afu_desc_ctrl #(.ADDR_W(ADDR_W), .LATENCY(LATENCY)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .flagBit(regWdata[31]), .strb(strb)
  );

  afu_desc_dp #(
    .ADDR_W(ADDR_W), .PRESENT_MASK(PRESENT_MASK), .HDR_MAJOR(HDR_MAJOR),
    .HDR_MINOR(HDR_MINOR), .AFU_MAJOR(AFU_MAJOR), .AFU_MINOR(AFU_MINOR),
    .GLOBAL_SIZE(GLOBAL_SIZE), .PP_STRIDE(PP_STRIDE), .MEM_LOG2(MEM_LOG2)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .idxQ(idxQ),
    .offsetQ(offsetQ), .dataQ(dataQ), .validQ(validQ)
  );
endmodule

// File: rtl/afu_desc_check.sv
module afu_desc_check #(
  parameter int ADDR_W  = 2,
  parameter int LATENCY = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] regAddr,
  input logic              regWe,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic [30:0]       offsetQ,
  input logic [31:0]       dataQ,
  input logic              validQ
);
  localparam int SINCE_W = $clog2(LATENCY + 2) + 1;
  localparam logic [SINCE_W-1:0] SINCE_MAX = SINCE_W'(LATENCY + 1);

  logic [SINCE_W-1:0] sinceWr;
  logic acceptedWr;

  assign acceptedWr = regWe && (regAddr == ADDR_W'(1)) && !regWdata[31];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  sinceWr <= SINCE_MAX;
    else if (acceptedWr)        sinceWr <= '0;
    else if (sinceWr < SINCE_MAX) sinceWr <= sinceWr + 1'b1;
  end

  assert_index_upper_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(0)) |-> (regRdata[31:6] == 26'h0));

  assert_offset_write_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    acceptedWr |=> !validQ);

  assert_ready_latency_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validQ) |-> (sinceWr == SINCE_W'(LATENCY)));

  assert_flag_write_dropped_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(1) && regWdata[31]) |=> $stable(offsetQ));

  assert_index_write_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == ADDR_W'(0)) |=> !validQ);

  assert_data_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dataQ) |-> $rose(validQ));
endmodule

bind afu_desc_port afu_desc_check #(.ADDR_W(ADDR_W), .LATENCY(LATENCY)) u_chk (
  .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
  .regWdata(regWdata), .regRdata(regRdata), .offsetQ(offsetQ),
  .dataQ(dataQ), .validQ(validQ)
);

// File: tb/afu_desc_port_tb.sv
module afu_desc_port_tb;
  localparam int LAT = 4;
  localparam logic [63:0] MASK = 64'h0000_0000_0000_0015;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regAddr = '0;
  logic        regWe = 1'b0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  afu_desc_port #(.LATENCY(LAT), .PRESENT_MASK(MASK)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata)
  );

  function automatic logic [31:0] expDesc(input logic [5:0] idx, input logic [30:0] off);
    logic [30:0] a;
    a = {off[30:2], 2'b00};
    if (!MASK[idx] || a >= 31'h58) return 32'h0;
    case (a)
      31'h00: return 32'h0058_0100;
      31'h04: return 32'h2D63_6361;
      31'h08: return {16'h0, 8'h30 + 8'(idx[2:0]), 8'h30 + 8'(idx[5:3])};
      31'h1C: return {8'h02, 8'h03, 4'b0110, 4'h0, 2'b00, idx};
      31'h20: return {10'h0, idx, 16'h0002};
      31'h24: return 32'h1;
      31'h28: return 32'h0200_0000;
      31'h30: return {10'h0, idx, 16'h0004};
      31'h38: return 32'h0001_0000;
      31'h3C: return 32'd24;
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #0.5;
    d = regRdata;
  endtask

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // fetch with exact ready timing, returns data
  task automatic fetch(input string req, input logic [30:0] off, output logic [31:0] d);
    logic [31:0] r;
    writeReg(2'd1, {1'b0, off});
    waitNeg(LAT - 1);
    readReg(2'd1, r);
    check({req, " R2 not ready one edge early"}, {31'h0, r[31]}, 32'h0);
    waitNeg(1);
    readReg(2'd1, r);
    check({req, " R2 ready at latency"}, r, {1'b1, off});
    readReg(2'd2, d);
  endtask

  task automatic testReset();
    logic [31:0] r;
    readReg(2'd0, r); check("R1 reset index", r, 32'h0);
    readReg(2'd1, r); check("R1 reset offset", r, 32'h0);
    readReg(2'd2, r); check("R1 reset data", r, 32'h0);
    writeReg(2'd0, 32'hFFFF_FFC2);
    readReg(2'd0, r); check("R1 index upper bits dropped", r, 32'h2);
    readReg(2'd3, r); check("R1 spare address zero", r, 32'h0);
  endtask

  task automatic testHeaders();
    logic [31:0] d;
    writeReg(2'd0, 32'd0);
    fetch("R7 slot0", 31'h0, d); check("R7 header slot0", d, expDesc(6'd0, 31'h0));
    writeReg(2'd0, 32'd1);
    fetch("R7 slot1", 31'h0, d); check("R7 empty slot header", d, 32'h0);
    fetch("R7 slot1", 31'h1C, d); check("R7 empty slot other word", d, 32'h0);
    writeReg(2'd0, 32'd63);
    fetch("R7 slot63", 31'h0, d); check("R7 empty top slot", d, 32'h0);
  endtask

  task automatic testFields();
    logic [31:0] d;
    for (int s = 2; s <= 4; s += 2) begin
      writeReg(2'd0, 32'(s));
      fetch("R8", 31'h04, d); check("R8 name word0", d, expDesc(6'(s), 31'h04));
      fetch("R8", 31'h08, d); check("R8 name word1", d, expDesc(6'(s), 31'h08));
      fetch("R8", 31'h14, d); check("R8 name tail zero", d, 32'h0);
      fetch("R9", 31'h1C, d); check("R9 version/type word", d, expDesc(6'(s), 31'h1C));
      for (int o = 'h20; o <= 'h3C; o += 4) begin
        fetch("R10", 31'(o), d); check("R10 mmio word", d, expDesc(6'(s), 31'(o)));
      end
    end
  endtask

  task automatic testBounds();
    logic [31:0] d;
    writeReg(2'd0, 32'd2);
    fetch("R11", 31'h58, d); check("R11 at template length", d, 32'h0);
    fetch("R11", 31'h7FFF_FFFC, d); check("R11 far offset", d, 32'h0);
    fetch("R11", 31'h40, d); check("R11 gap inside template", d, 32'h0);
    fetch("R11", 31'h1E, d); check("R11 unaligned offset", d, expDesc(6'd2, 31'h1C));
  endtask

  task automatic testFlagWrite();
    logic [31:0] d, r;
    writeReg(2'd0, 32'd4);
    fetch("R3", 31'h28, d);
    writeReg(2'd1, 32'h8000_0004);
    readReg(2'd1, r); check("R3 flag write dropped offset/ready", r, {1'b1, 31'h28});
    waitNeg(LAT + 2);
    readReg(2'd1, r); check("R3 still ready later", r, {1'b1, 31'h28});
    readReg(2'd2, r); check("R3 data unchanged", r, 32'h0200_0000);
  endtask

  task automatic testRestart();
    logic [31:0] r;
    writeReg(2'd0, 32'd2);
    writeReg(2'd1, 32'h0000_0038);
    waitNeg(1);
    writeReg(2'd1, 32'h0000_001C);
    waitNeg(LAT - 1);
    readReg(2'd1, r); check("R4 restart not early", {31'h0, r[31]}, 32'h0);
    readReg(2'd2, r); check("R6 stale data while pending", r, 32'h0200_0000);
    waitNeg(1);
    readReg(2'd1, r); check("R4 ready after restart", r, {1'b1, 31'h1C});
    readReg(2'd2, r); check("R4 data from new offset", r, expDesc(6'd2, 31'h1C));
  endtask

  task automatic testIndexCancel();
    logic [31:0] r;
    writeReg(2'd1, 32'h0000_0020);
    writeReg(2'd0, 32'd4);
    readReg(2'd1, r); check("R5 index write clears ready", r, {1'b0, 31'h20});
    waitNeg(LAT + 3);
    readReg(2'd1, r); check("R5 fetch cancelled", r, {1'b0, 31'h20});
    readReg(2'd2, r); check("R6 data held after cancel", r, expDesc(6'd2, 31'h1C));
    writeReg(2'd0, 32'd4);
    readReg(2'd2, r); check("R6 data held after index write", r, expDesc(6'd2, 31'h1C));
  endtask

  initial begin
    waitNeg(3);
    rstN = 1'b1;
    waitNeg(1);
    testReset();
    testHeaders();
    testFields();
    testBounds();
    testFlagWrite();
    testRestart();
    testIndexCancel();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule